// File: doc/BRIEF.md
# Branch and Code Address Generator

This block produces the next program-counter value and the code-memory lookup addresses for an 8-bit microcontroller core with a 16-bit, 64K-byte program space. The fetch logic supplies the address of the first byte of the instruction that follows the current one, and the decoder supplies a 3-bit form selector. The same inputs carry the operands of the current instruction: an 11-bit page operand, a 16-bit absolute operand, a signed 8-bit displacement, the accumulator and the 16-bit data pointer. A taken flag from the condition logic, which is outside this block, decides whether a branch form is followed.

The selected address appears combinationally on `addrOut`. It serves either as a jump or call destination or as a table-lookup address into code memory. A program-counter register inside the block copies `addrOut` only on a clock edge where the load strobe is high. Pushing return addresses, sequencing fetches and evaluating conditions are left to neighbouring blocks.

Top module: `branch_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with `loadEn` low, `pc` holds 0x0000.
- R2: Form code 1 (long) with `condTaken`=1 drives `addrOut` to the full 16-bit `absOpnd`.
- R3: Form code 2 (page) with `condTaken`=1 drives `addrOut[15:11]` from `nextPc[15:11]` and `addrOut[10:0]` from `pageOpnd`. When `nextPc` has already crossed into the following 2K page, the result lies in that page.
- R4: Form code 3 (relative) with `condTaken`=1 drives `addrOut` to `nextPc` plus the sign-extended `relOfs` (range -128 to +127), modulo 65536.
- R5: Form codes 1, 2 and 3 with `condTaken`=0 drive `addrOut` to `nextPc`.
- R6: Form code 4 drives `addrOut` to the zero-extended `acc` plus `dptr`, modulo 65536, whatever the value of `condTaken`.
- R7: Form code 5 drives `addrOut` to the zero-extended `acc` plus `nextPc`, modulo 65536, whatever the value of `condTaken`.
- R8: Form code 0 (sequential) and the unused codes 6 and 7 drive `addrOut` to `nextPc`.
- R9: On a clock edge with `loadEn`=1, `pc` takes the value `addrOut` had before that edge. With `loadEn`=0, `pc` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the PC register |
| formSel | input | 3 | Address form code (0 seq, 1 long, 2 page, 3 relative, 4 acc+dptr, 5 acc+pc) |
| condTaken | input | 1 | Branch condition result; gates forms 1 to 3 |
| nextPc | input | 16 | Address of the first byte of the following instruction |
| pageOpnd | input | 11 | In-page target operand |
| absOpnd | input | 16 | Absolute target operand |
| relOfs | input | 8 | Signed two's-complement displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| loadEn | input | 1 | Strobe that copies `addrOut` into `pc` |
| addrOut | output | 16 | Selected target or lookup address (combinational) |
| pc | output | 16 | Program-counter register |

## Verification
The block has no hidden state apart from `pc`. A wrong strobe decode or a wrong adder operand therefore appears on `addrOut` in the same cycle as the stimulus, as soon as a form code, a displacement sign or a page-boundary operand exercises it. A faulty load path appears on `pc` one edge after the strobe, either as a missed update or as drift while the strobe is low. The sweeps cover every displacement and every accumulator value against page-edge and wrap-around base addresses, so carry and sign-extension errors show within the first few hundred cycles.

// File: rtl/brgen_pkg.sv
package brgen_pkg;

  typedef enum logic [2:0] {
    FORM_SEQ     = 3'd0,
    FORM_LONG    = 3'd1,
    FORM_PAGE    = 3'd2,
    FORM_REL     = 3'd3,
    FORM_TBL_PTR = 3'd4,
    FORM_TBL_PC  = 3'd5
  } form_e;

  // strobes from control to datapath; at most one pick* is high
  typedef struct packed {
    logic pickLong;
    logic pickPage;
    logic pickRel;
    logic pickTbl;
    logic tblFromPc;
  } selStrobe_t;

endpackage

// File: rtl/brgen_ctrl.sv
module brgen_ctrl
  import brgen_pkg::*;
(
  input  logic [2:0]  formSel,
  input  logic        condTaken,
  output selStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    case (formSel)
      FORM_LONG:    strobe.pickLong = condTaken;
      FORM_PAGE:    strobe.pickPage = condTaken;
      FORM_REL:     strobe.pickRel  = condTaken;
      FORM_TBL_PTR: strobe.pickTbl  = 1'b1;
      FORM_TBL_PC: begin
        strobe.pickTbl   = 1'b1;
        strobe.tblFromPc = 1'b1;
      end
      default:      strobe = '0;
    endcase
  end

endmodule

// File: rtl/brgen_dp.sv
module brgen_dp
  import brgen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int ACC_W  = 8
) (
  input  selStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   nextPc,
  input  logic [PAGE_W-1:0]   pageOpnd,
  input  logic [ADDR_W-1:0]   absOpnd,
  input  logic [OFS_W-1:0]    relOfs,
  input  logic [ACC_W-1:0]    acc,
  input  logic [ADDR_W-1:0]   dptr,
  output logic [ADDR_W-1:0]   addrOut
);

  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] relExt;
  logic [ADDR_W-1:0] accExt;
  logic [ADDR_W-1:0] tblBase;
  logic [ADDR_W-1:0] relSum;
  logic [ADDR_W-1:0] tblSum;
  logic [ADDR_W-1:0] pageTgt;

  assign relExt  = {{(ADDR_W-OFS_W){relOfs[OFS_W-1]}}, relOfs};
  assign accExt  = {{(ADDR_W-ACC_W){1'b0}}, acc};
  assign tblBase = strobe.tblFromPc ? nextPc : dptr;
  assign relSum  = nextPc + relExt;
  assign tblSum  = accExt + tblBase;
  assign pageTgt = {nextPc[ADDR_W-1 -: HI_W], pageOpnd};

  always_comb begin
    if (strobe.pickLong)      addrOut = absOpnd;
    else if (strobe.pickPage) addrOut = pageTgt;
    else if (strobe.pickRel)  addrOut = relSum;
    else if (strobe.pickTbl)  addrOut = tblSum;
    else                      addrOut = nextPc;
  end

endmodule

// File: rtl/branch_addr_gen.sv
module branch_addr_gen
  import brgen_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              PAGE_W   = 11,
  parameter int              OFS_W    = 8,
  parameter int              ACC_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        formSel,
  input  logic              condTaken,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [PAGE_W-1:0] pageOpnd,
  input  logic [ADDR_W-1:0] absOpnd,
  input  logic [OFS_W-1:0]  relOfs,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic              loadEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] pc
);

  selStrobe_t strobe;

  brgen_ctrl u_ctrl (
    .formSel   (formSel),
    .condTaken (condTaken),
    .strobe    (strobe)
  );

  brgen_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .OFS_W  (OFS_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .strobe   (strobe),
    .nextPc   (nextPc),
    .pageOpnd (pageOpnd),
    .absOpnd  (absOpnd),
    .relOfs   (relOfs),
    .acc      (acc),
    .dptr     (dptr),
    .addrOut  (addrOut)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      pc <= RESET_PC;
    else if (loadEn) pc <= addrOut;
  end

endmodule

// File: rtl/brgen_checker.sv
module brgen_checker #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        formSel,
  input logic              condTaken,
  input logic [ADDR_W-1:0] nextPc,
  input logic [PAGE_W-1:0] pageOpnd,
  input logic [ADDR_W-1:0] absOpnd,
  input logic              loadEn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [ADDR_W-1:0] pc
);

  localparam int HI_W = ADDR_W - PAGE_W;

  p_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (formSel == 3'd1 && condTaken) |-> addrOut == absOpnd);

  p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (formSel == 3'd2 && condTaken) |->
      (addrOut[ADDR_W-1 -: HI_W] == nextPc[ADDR_W-1 -: HI_W]) &&
      (addrOut[PAGE_W-1:0] == pageOpnd));

  p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (formSel inside {3'd1, 3'd2, 3'd3} && !condTaken) |-> addrOut == nextPc);

  p_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (formSel inside {3'd0, 3'd6, 3'd7}) |-> addrOut == nextPc);

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |=> pc == $past(addrOut));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !loadEn |=> $stable(pc));

endmodule

bind branch_addr_gen brgen_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .formSel   (formSel),
  .condTaken (condTaken),
  .nextPc    (nextPc),
  .pageOpnd  (pageOpnd),
  .absOpnd   (absOpnd),
  .loadEn    (loadEn),
  .addrOut   (addrOut),
  .pc        (pc)
);

// File: tb/branch_addr_gen_bench.sv
`timescale 1ns/1ps
module branch_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  formSel = 3'd0;
  logic        condTaken = 1'b0;
  logic [15:0] nextPc = 16'h0;
  logic [10:0] pageOpnd = 11'h0;
  logic [15:0] absOpnd = 16'h0;
  logic [7:0]  relOfs = 8'h0;
  logic [7:0]  acc = 8'h0;
  logic [15:0] dptr = 16'h0;
  logic        loadEn = 1'b0;
  logic [15:0] addrOut;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_addr_gen u_branch_addr_gen (
    .clk(clk), .rst_n(rst_n), .formSel(formSel), .condTaken(condTaken),
    .nextPc(nextPc), .pageOpnd(pageOpnd), .absOpnd(absOpnd), .relOfs(relOfs),
    .acc(acc), .dptr(dptr), .loadEn(loadEn), .addrOut(addrOut), .pc(pc)
  );

  logic [15:0] bases [8] = '{16'h0000, 16'hFFFF, 16'h07FF, 16'h0800,
                             16'hF800, 16'h7F80, 16'h8000, 16'h1234};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic t);
    @(negedge clk);
    formSel = f;
    condTaken = t;
    #1;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] exp;
    // R1: reset value
    repeat (3) @(posedge clk);
    #1 check("R1 reset", pc, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after release", pc, 16'h0000);

    for (int b = 0; b < 8; b++) begin
      nextPc = bases[b];
      // R8: sequential and unused codes
      for (int f = 0; f < 8; f++) begin
        if (f == 0 || f >= 6) begin
          apply(3'(f), 1'b1);
          check("R8 seq", addrOut, nextPc);
        end
      end
      // R2 long / R5 not taken
      absOpnd = ~bases[b] ^ 16'h5A5A;
      apply(3'd1, 1'b1); check("R2 long", addrOut, absOpnd);
      apply(3'd1, 1'b0); check("R5 long not taken", addrOut, nextPc);
      // R3 page
      for (int p = 0; p < 2048; p += 97) begin
        pageOpnd = 11'(p);
        apply(3'd2, 1'b1);
        exp = (bases[b] & 16'hF800) | 16'(p);
        check("R3 page", addrOut, exp);
      end
      pageOpnd = 11'h7FF;
      apply(3'd2, 1'b0); check("R5 page not taken", addrOut, nextPc);
      // R4 relative, every displacement
      for (int o = -128; o < 128; o++) begin
        relOfs = 8'(o);
        apply(3'd3, 1'b1);
        exp = 16'((int'(bases[b]) + o + 65536) % 65536);
        check("R4 rel", addrOut, exp);
      end
      apply(3'd3, 1'b0); check("R5 rel not taken", addrOut, nextPc);
      // R6 / R7 table lookups, every accumulator value
      dptr = bases[(b + 3) % 8];
      for (int a = 0; a < 256; a++) begin
        acc = 8'(a);
        apply(3'd4, a[0]);
        exp = 16'((int'(dptr) + a) % 65536);
        check("R6 acc+dptr", addrOut, exp);
        apply(3'd5, a[1]);
        exp = 16'((int'(bases[b]) + a) % 65536);
        check("R7 acc+pc", addrOut, exp);
      end
    end

    // R3: next-instruction address crossed the page edge (0x07FF op -> 0x0800)
    nextPc = 16'h0800; pageOpnd = 11'h010;
    apply(3'd2, 1'b1); check("R3 next page", addrOut, 16'h0810);

    // R9: load and hold
    absOpnd = 16'hBEEF; nextPc = 16'h0100;
    apply(3'd1, 1'b1);
    loadEn = 1'b1;
    @(posedge clk); #1 check("R9 load", pc, 16'hBEEF);
    @(negedge clk) loadEn = 1'b0; absOpnd = 16'h1111;
    @(posedge clk); #1 check("R9 hold", pc, 16'hBEEF);
    @(posedge clk); #1 check("R9 hold2", pc, 16'hBEEF);
    relOfs = 8'hF0;
    apply(3'd3, 1'b1);
    loadEn = 1'b1;
    @(posedge clk); #1 check("R9 load rel", pc, 16'h00F0);
    @(negedge clk) loadEn = 1'b0;

    finishRun();
  end

endmodule